// File: doc/BRIEF.md
# Dual-Edge Input Capture Channel

This block timestamps the edges of one external input against a free-running PWM down-counter. The counter value arrives as an input bus. The input pin is first synchronized to the block clock. Its polarity can then be reversed. A rising edge of the resulting signal copies the counter into a rising-edge latch, and a falling edge copies it into a falling-edge latch. Each latch has its own "captured" indicator that hardware sets when the latch loads.

A shared capture flag collects the edges whose interrupt is enabled, and the flag drives the interrupt line. Software programs the channel through a small register port. Writes are registered and reads are combinational. The flag is cleared by writing 1. The two indicators are cleared by writing a chosen polarity, which a mode bit selects. A single enable bit turns the whole channel off: no latch update, no indicator, no flag and no interrupt.

Top module: `cap_channel`

## Requirements
- R1: After reset, all four registers read zero and `irq_out` is 0.
- R2: Once the channel is enabled (control bit 0 = 1), a rising edge of the conditioned input loads `cnt_val` into the rising latch (address 2) and sets the rising indicator (status bit 1).
- R3: Once the channel is enabled, a falling edge of the conditioned input loads `cnt_val` into the falling latch (address 3) and sets the falling indicator (status bit 2).
- R4: With the invert bit set (control bit 1 = 1), a rising pin edge counts as a falling edge and a falling pin edge counts as a rising edge. Toggling the invert bit alone causes no capture.
- R5: With control bit 0 = 0, pin edges change neither latch, set no indicator and set no flag.
- R6: A rising edge sets the capture flag (status bit 0) only when control bit 2 = 1. A falling edge sets it only when control bit 3 = 1.
- R7: Writing status with bit 0 = 1 clears the capture flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R8: With control bit 4 = 0, a status write clears each indicator whose data bit is 0. With control bit 4 = 1, it clears each indicator whose data bit is 1. An indicator whose data bit has the other value keeps its state.
- R9: When a hardware set and a software clear reach the flag or an indicator in the same cycle, the bit ends up set.
- R10: `irq_out` equals the capture flag ANDed with control bit 0.
- R11: A pin change is captured on the third rising clock edge after it, using the `cnt_val` present at that edge.
- R12: The address map is 0 control (bits 4:0, upper read bits zero), 1 status (bits 2:0), 2 rising latch and 3 falling latch. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous external input to capture |
| cnt_val | input | CNT_W | Current PWM down-counter value |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for reads and writes |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |
| irq_out | output | 1 | Capture interrupt |

## Verification
Mistakes in the synchronizer or the edge detector show up as a latch value or indicator that changes one cycle too early or too late. Such a fault is visible at `bus_rdata` on the cycle that follows the third clock edge after the pin moves. A wrong edge polarity under inversion, or a wrong clear polarity, loads the wrong latch or leaves the wrong status bit. The status read made right after the stimulus exposes it. A broken set-versus-clear priority is forced into view by a status write that lands on the same cycle as a capture, and the status read right after that write shows the lost bit.

// File: rtl/cap_chan_pkg.sv
package cap_chan_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_RISE = 2'd2,
    REG_FALL = 2'd3
  } reg_sel_e;

  // control register, bit 0 at the bottom
  typedef struct packed {
    logic clr_mode;  // bit 4
    logic fall_ie;   // bit 3
    logic rise_ie;   // bit 2
    logic invert;    // bit 1
    logic enable;    // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int STAT_W = 3;

  localparam int EDGE_RISE = 0;
  localparam int EDGE_FALL = 1;
  localparam int N_EDGES   = 2;

  // an indicator is cleared when the written bit matches the mode bit
  function automatic logic ind_clear_hit(input logic wbit, input logic mode);
    return wbit == mode;
  endfunction

  // sticky bit update, hardware set dominates software clear
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return set | (cur & ~clr);
  endfunction

  // map raw pin edges to conditioned edges through the polarity selector
  function automatic logic [N_EDGES-1:0] steer_edges(input logic raw_up,
                                                     input logic raw_dn,
                                                     input logic inv);
    logic [N_EDGES-1:0] r;
    r[EDGE_RISE] = inv ? raw_dn : raw_up;
    r[EDGE_FALL] = inv ? raw_up : raw_dn;
    return r;
  endfunction

endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
  import cap_chan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin,
  input  logic               invert,
  input  logic               enable,
  output logic [N_EDGES-1:0] evt
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   raw_up;
  logic                   raw_dn;

  // synchronizer chain, stage 0 samples the pin
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  // previous sample of the un-inverted level, so flipping polarity makes no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign raw_up = sync_q[LAST] & ~prev_q;
  assign raw_dn = ~sync_q[LAST] & prev_q;

  assign evt = enable ? steer_edges(raw_up, raw_dn, invert) : '0;

endmodule

// File: rtl/cap_latch.sv
module cap_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

endmodule

// File: rtl/cap_regs.sv
module cap_regs
  import cap_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [CTRL_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  input  logic [N_EDGES-1:0] evt,
  input  logic [CNT_W-1:0]   rise_q,
  input  logic [CNT_W-1:0]   fall_q,
  output ctrl_t              ctrl,
  output logic               cap_flag,
  output logic [N_EDGES-1:0] ind,
  output logic               flag_set
);

  logic ctrl_wr;
  logic stat_wr;
  logic flag_clr;
  logic [N_EDGES-1:0] ind_clr;
  logic [STAT_W-1:0]  stat_view;

  assign ctrl_wr  = bus_wr && (bus_addr == REG_CTRL);
  assign stat_wr  = bus_wr && (bus_addr == REG_STAT);
  assign flag_clr = stat_wr && bus_wdata[0];
  assign flag_set = (evt[EDGE_RISE] && ctrl.rise_ie) ||
                    (evt[EDGE_FALL] && ctrl.fall_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_flag <= 1'b0;
    else        cap_flag <= sticky_next(cap_flag, flag_set, flag_clr);
  end

  // indicator i lives at status bit i+1
  generate
    for (genvar e = 0; e < N_EDGES; e++) begin : g_ind
      assign ind_clr[e] = stat_wr && ind_clear_hit(bus_wdata[e+1], ctrl.clr_mode);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ind[e] <= 1'b0;
        else        ind[e] <= sticky_next(ind[e], evt[e], ind_clr[e]);
      end
    end
  endgenerate

  assign stat_view = {ind, cap_flag};

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      REG_CTRL: bus_rdata = CNT_W'(ctrl);
      REG_STAT: bus_rdata = CNT_W'(stat_view);
      REG_RISE: bus_rdata = rise_q;
      REG_FALL: bus_rdata = fall_q;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_pin,
  input  logic [CNT_W-1:0]          cnt_val,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [CTRL_W-1:0]         bus_wdata,
  output logic [CNT_W-1:0]          bus_rdata,
  output logic                      irq_out
);

  ctrl_t              ctrl;
  logic [N_EDGES-1:0] evt;
  logic [N_EDGES-1:0] ind;
  logic [CNT_W-1:0]   latch_q [N_EDGES];
  logic               cap_flag;
  logic               flag_set;
  logic               cap_en;
  logic               rise_evt;
  logic               fall_evt;
  logic               rise_ind;
  logic               fall_ind;
  logic               rise_ie;
  logic [CNT_W-1:0]   rise_q;
  logic [CNT_W-1:0]   fall_q;

  cap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (cap_pin),
    .invert (ctrl.invert),
    .enable (ctrl.enable),
    .evt    (evt)
  );

  generate
    for (genvar e = 0; e < N_EDGES; e++) begin : g_latch
      cap_latch #(.W(CNT_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (evt[e]),
        .din   (cnt_val),
        .q     (latch_q[e])
      );
    end
  endgenerate

  assign rise_q = latch_q[EDGE_RISE];
  assign fall_q = latch_q[EDGE_FALL];

  cap_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt       (evt),
    .rise_q    (rise_q),
    .fall_q    (fall_q),
    .ctrl      (ctrl),
    .cap_flag  (cap_flag),
    .ind       (ind),
    .flag_set  (flag_set)
  );

  // named events for the checker
  assign cap_en   = ctrl.enable;
  assign rise_ie  = ctrl.rise_ie;
  assign rise_evt = evt[EDGE_RISE];
  assign fall_evt = evt[EDGE_FALL];
  assign rise_ind = ind[EDGE_RISE];
  assign fall_ind = ind[EDGE_FALL];

  assign irq_out = cap_flag & cap_en;

endmodule

// File: rtl/cap_channel_sva.sv
module cap_channel_sva
  import cap_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wflag_clr,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              irq_out,
  input logic              cap_en,
  input logic              rise_evt,
  input logic              fall_evt,
  input logic              rise_ind,
  input logic              fall_ind,
  input logic              cap_flag,
  input logic              flag_set,
  input logic [CNT_W-1:0]  rise_q,
  input logic [CNT_W-1:0]  fall_q
);

  logic stat_wr;
  assign stat_wr = bus_wr && (bus_addr == REG_STAT);

  assert_rise_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (rise_q == $past(cnt_val)) && rise_ind);

  assert_fall_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (fall_q == $past(cnt_val)) && fall_ind);

  assert_one_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_evt, fall_evt}));

  assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(rise_q) && $stable(fall_q));

  assert_no_spurious_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_flag && !flag_set) |=> !cap_flag);

  assert_flag_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wflag_clr && !flag_set) |=> !cap_flag);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> cap_flag);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> !irq_out);

endmodule

bind cap_channel cap_channel_sva #(.CNT_W(CNT_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .wflag_clr (bus_wdata[0]),
  .cnt_val   (cnt_val),
  .irq_out   (irq_out),
  .cap_en    (cap_en),
  .rise_evt  (rise_evt),
  .fall_evt  (fall_evt),
  .rise_ind  (rise_ind),
  .fall_ind  (fall_ind),
  .cap_flag  (cap_flag),
  .flag_set  (flag_set),
  .rise_q    (rise_q),
  .fall_q    (fall_q)
);

// File: tb/cap_channel_tb.sv
module cap_channel_tb;

  localparam int CLK_P = 10;
  localparam int W     = 16;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_RISE = 2'd2;
  localparam logic [1:0] A_FALL = 2'd3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cap_pin;
  logic [W-1:0] cnt_val;
  logic         bus_wr;
  logic [1:0]   bus_addr;
  logic [4:0]   bus_wdata;
  logic [W-1:0] bus_rdata;
  logic         irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cap_channel #(.CNT_W(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_pin   (cap_pin),
    .cnt_val   (cnt_val),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [W-1:0] exp);
    logic [W-1:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // change the pin and wait until the capture has settled
  task automatic drive_pin(input logic v, input logic [W-1:0] c);
    @(negedge clk);
    cnt_val = c;
    cap_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", A_CTRL, 16'h0);
    rd_chk("R1 stat", A_STAT, 16'h0);
    rd_chk("R1 rise", A_RISE, 16'h0);
    rd_chk("R1 fall", A_FALL, 16'h0);
    chk("R1 irq", irq_out, 1'b0);
  endtask

  task automatic t_rise();
    wr(A_CTRL, 5'b00001);
    drive_pin(1'b1, 16'h1234);
    rd_chk("R2 rise latch", A_RISE, 16'h1234);
    rd_chk("R2 fall untouched", A_FALL, 16'h0);
    rd_chk("R2 stat", A_STAT, 16'h2);
    chk("R6 no irq without enable", irq_out, 1'b0);
  endtask

  task automatic t_fall();
    drive_pin(1'b0, 16'hABCD);
    rd_chk("R3 fall latch", A_FALL, 16'hABCD);
    rd_chk("R3 rise kept", A_RISE, 16'h1234);
    rd_chk("R3 stat", A_STAT, 16'h6);
  endtask

  task automatic t_clear_mode0();
    wr(A_STAT, 5'b00000);
    rd_chk("R8 mode0 write0 clears", A_STAT, 16'h0);
    drive_pin(1'b1, 16'h0055);
    wr(A_STAT, 5'b00010);
    rd_chk("R8 mode0 write1 keeps", A_STAT, 16'h2);
    wr(A_STAT, 5'b00000);
    rd_chk("R8 mode0 clear again", A_STAT, 16'h0);
  endtask

  task automatic t_clear_mode1();
    wr(A_CTRL, 5'b10001);
    drive_pin(1'b0, 16'h0101);
    wr(A_STAT, 5'b00000);
    rd_chk("R8 mode1 write0 keeps", A_STAT, 16'h4);
    wr(A_STAT, 5'b00100);
    rd_chk("R8 mode1 write1 clears", A_STAT, 16'h0);
  endtask

  task automatic t_irq_enables();
    wr(A_CTRL, 5'b00101);
    drive_pin(1'b1, 16'h0202);
    rd_chk("R6 rise sets flag", A_STAT, 16'h3);
    chk("R10 irq high", irq_out, 1'b1);
    wr(A_STAT, 5'b00001);
    rd_chk("R7 flag cleared", A_STAT, 16'h0);
    chk("R10 irq low", irq_out, 1'b0);
    drive_pin(1'b0, 16'h0303);
    rd_chk("R6 fall no flag", A_STAT, 16'h4);
    wr(A_CTRL, 5'b01001);
    drive_pin(1'b1, 16'h0404);
    rd_chk("R6 rise no flag", A_STAT, 16'h6);
    drive_pin(1'b0, 16'h0505);
    rd_chk("R6 fall sets flag", A_STAT, 16'h7);
    chk("R10 irq fall", irq_out, 1'b1);
  endtask

  task automatic t_flag_write0();
    wr(A_STAT, 5'b00110);
    rd_chk("R7 write0 keeps flag", A_STAT, 16'h7);
    wr(A_STAT, 5'b00001);
    rd_chk("R7 write1 clears all", A_STAT, 16'h0);
  endtask

  task automatic t_irq_gate();
    drive_pin(1'b1, 16'h0606);
    drive_pin(1'b0, 16'h0707);
    wr(A_CTRL, 5'b01000);
    chk("R10 irq gated off", irq_out, 1'b0);
    rd_chk("R10 flag still set", A_STAT, 16'h7);
    wr(A_CTRL, 5'b01001);
    chk("R10 irq back", irq_out, 1'b1);
    wr(A_STAT, 5'b00001);
  endtask

  task automatic t_disabled();
    logic [W-1:0] r0, f0;
    wr(A_CTRL, 5'b01100);
    rd(A_RISE, r0);
    rd(A_FALL, f0);
    drive_pin(1'b1, 16'h7777);
    drive_pin(1'b0, 16'h8888);
    rd_chk("R5 rise frozen", A_RISE, r0);
    rd_chk("R5 fall frozen", A_FALL, f0);
    rd_chk("R5 no status", A_STAT, 16'h0);
    chk("R5 no irq", irq_out, 1'b0);
  endtask

  task automatic t_invert();
    wr(A_CTRL, 5'b00011);
    wr(A_CTRL, 5'b00001);
    wr(A_CTRL, 5'b00011);
    repeat (4) @(negedge clk);
    rd_chk("R4 toggle no capture", A_STAT, 16'h0);
    drive_pin(1'b1, 16'h4242);
    rd_chk("R4 pin up to fall latch", A_FALL, 16'h4242);
    rd_chk("R4 stat fall", A_STAT, 16'h4);
    drive_pin(1'b0, 16'h2424);
    rd_chk("R4 pin down to rise latch", A_RISE, 16'h2424);
    rd_chk("R4 stat both", A_STAT, 16'h6);
    wr(A_STAT, 5'b00001);
  endtask

  task automatic t_latency();
    wr(A_CTRL, 5'b00001);
    @(negedge clk);
    cnt_val = 16'h1111;
    cap_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_chk("R11 not yet loaded", A_RISE, 16'h2424);
    cnt_val = 16'h2222;
    @(negedge clk);
    rd_chk("R11 loaded on third edge", A_RISE, 16'h2222);
    cnt_val = 16'h3333;
    repeat (2) @(negedge clk);
    rd_chk("R11 value held", A_RISE, 16'h2222);
    wr(A_STAT, 5'b00001);
  endtask

  task automatic t_priority();
    wr(A_CTRL, 5'b00101);
    @(negedge clk);
    cnt_val = 16'h5A5A;
    cap_pin = 1'b0;
    repeat (4) @(negedge clk);
    wr(A_STAT, 5'b00001);
    rd_chk("R9 start clear", A_STAT, 16'h0);
    @(negedge clk);
    cap_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 5'b00001;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_chk("R9 set beats clear", A_STAT, 16'h3);
    rd_chk("R9 latch loaded", A_RISE, 16'h5A5A);
  endtask

  task automatic t_map();
    logic [W-1:0] r0, f0;
    rd(A_RISE, r0);
    rd(A_FALL, f0);
    wr(A_RISE, 5'h1F);
    wr(A_FALL, 5'h1F);
    rd_chk("R12 rise read only", A_RISE, r0);
    rd_chk("R12 fall read only", A_FALL, f0);
    wr(A_CTRL, 5'h1E);
    rd_chk("R12 ctrl readback", A_CTRL, 16'h001E);
  endtask

  initial begin
    rst_n = 1'b0; cap_pin = 1'b0; cnt_val = '0;
    bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_clear_mode0();
    t_clear_mode1();
    t_irq_enables();
    t_flag_write0();
    t_irq_gate();
    t_disabled();
    t_invert();
    t_latency();
    t_priority();
    t_map();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule